// File: doc/BRIEF.md
# Repeat-Mode DMA Channel Engine

This block is a single DMA channel that moves data between memory and a fixed I/O location in repeat mode. Each transfer request moves one byte or one 16-bit word. The memory side uses a 24-bit address that steps up or down after each transfer. The I/O side uses a 24-bit address made of an 8-bit register with all upper bits set to one, and that address never changes.

A working counter counts down the transfers in the current block. When it reaches zero, two things happen in the same cycle: the counter is reloaded from a second register, and the memory address is rewound to where the block started. The channel then carries on with no interrupt. Software stops the channel by clearing the enable bit. Setting enable again resumes from the exact address and count that were held when it stopped.

The CPU programs the channel through a narrow register write port. A simple two-way bus handshake carries each transfer: the channel raises `busReq`, and the bus answers with `busDone`.

Top module: `dma_repeat_channel`

## Requirements
- R1: After reset, `busReq` is low, the memory address, the I/O low byte, both counters and all control bits are zero. With the route bit clear, `srcAddr` reads 0xFFFF00 and `dstAddr` reads 0x000000.
- R2: When `xferReq` is high at a clock edge and the channel is enabled and idle, `busReq` is high from the next cycle. It stays high until the edge at which `busDone` is seen, then falls. Each request produces exactly one transfer.
- R3: Requests that arrive while enable is clear start no transfer and are not remembered. Enabling the channel later, with no new request, leaves `busReq` low.
- R4: A request that arrives while a transfer is in flight is held. A new transfer starts one idle cycle after the edge that completes the current one.
- R5: At the `busDone` edge the memory address moves by 1 for byte size or 2 for word size. It moves up when the decrement bit is clear and down when it is set. The address wraps modulo 2^24.
- R6: The working count drops by one at each `busDone` edge. A step that takes it to zero reloads it from the reload register in that same edge.
- R7: On the block-ending step, the memory address becomes the stepped address minus (+1 or -1, by direction) × (1 or 2, by size) × N, where N is the reload value. This returns it to the block's start address.
- R8: The I/O address is 0xFFFF in the upper 16 bits and the I/O low byte below them. It never steps. With the route bit set, `srcAddr` is the memory address and `dstAddr` is the I/O address; with it clear, the two are swapped.
- R9: Clearing enable, then setting it again, keeps the memory address and the working count. The next transfer uses the position that was current when enable was cleared.
- R10: A reload value of zero gives blocks of 256 transfers, and the rewind uses N = 256.
- R11: Register select codes on `regSel`:
  - 0 is the memory address (24 bits).
  - 1 is the I/O low byte.
  - 2 is the working count.
  - 3 is the reload count.
  - 4 is control: bit0 enable, bit1 word size, bit2 decrement, bit3 route memory-to-I/O.

  A write takes effect at the clock edge where `regWrEn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| xferReq | input | 1 | Transfer request strobe |
| regWrEn | input | 1 | Register write enable |
| regSel | input | 3 | Register select code |
| regWrData | input | 24 | Register write data |
| busDone | input | 1 | Bus has completed the current transfer |
| busReq | output | 1 | Bus transfer request, held until done |
| srcAddr | output | 24 | Source address of the transfer |
| dstAddr | output | 24 | Destination address of the transfer |
| xferWord | output | 1 | 1 = word transfer, 0 = byte transfer |

## Verification
The main stepping function is run under four patterns:
- Byte increment, memory to I/O.
- Word decrement, I/O to memory.
- Word decrement starting at address zero, which shows modulo wrap against sign errors in the rewind.
- A 256-transfer block loaded with a zero count, which shows the 256 interpretation against a skipped reload.

Short blocks of two and three transfers place the reload at a known step, so a one-off error in when the block ends shows up as a wrong address. Other patterns cover the flow control:
- A request raised mid-transfer separates holding a request from dropping it.
- Requests made while disabled, followed by a pause and resume, separate ignoring a request from queuing it and from losing position.

// File: rtl/dmarep_pkg.sv
package dmarep_pkg;

  typedef enum logic [2:0] {
    SEL_MEM  = 3'd0,
    SEL_IO   = 3'd1,
    SEL_WCNT = 3'd2,
    SEL_RCNT = 3'd3,
    SEL_CTRL = 3'd4
  } regSel_t;

  typedef struct packed {
    logic step;
  } ctrlStrobes_t;

endpackage

// File: rtl/dmarep_ctrl.sv
module dmarep_ctrl (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     xferReq,
  input  logic                     busDone,
  input  logic                     chanEn,
  output logic                     busReq,
  output dmarep_pkg::ctrlStrobes_t strobes
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_t;
  state_t state;
  logic   pendReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pendReq <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (chanEn && (xferReq || pendReq)) state <= ST_BUSY;
          pendReq <= 1'b0;
        end
        ST_BUSY: begin
          if (busDone) state <= ST_IDLE;
          if (!chanEn)      pendReq <= 1'b0;
          else if (xferReq) pendReq <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busReq       = (state == ST_BUSY);
  assign strobes.step = busReq && busDone;

  AST_OFF_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !chanEn) |=> !busReq); // R3
  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busDone) |=> busReq); // R2
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busDone) |=> !busReq); // R4
endmodule

// File: rtl/dmarep_datapath.sv
module dmarep_datapath #(
  parameter int AddrW = 24,
  parameter int CntW  = 8,
  parameter int IoW   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWrEn,
  input  dmarep_pkg::regSel_t      regSel,
  input  logic [AddrW-1:0]         regWrData,
  input  dmarep_pkg::ctrlStrobes_t strobes,
  output logic                     chanEn,
  output logic [AddrW-1:0]         srcAddr,
  output logic [AddrW-1:0]         dstAddr,
  output logic                     xferWord
);
  import dmarep_pkg::*;
  localparam int SpanW = CntW + 2;

  logic [AddrW-1:0] memAddr, memNext, stepAmt, rewind, ioAddr;
  logic [IoW-1:0]   ioLow;
  logic [CntW-1:0]  workCnt, reloadCnt;
  logic [SpanW-1:0] blockLen, span;
  logic             sizeWord, decMode, memToIo, lastXfer;
  logic             wrMem, wrIo, wrWork, wrReload, wrCtrl;

  assign wrMem    = regWrEn && (regSel == SEL_MEM);
  assign wrIo     = regWrEn && (regSel == SEL_IO);
  assign wrWork   = regWrEn && (regSel == SEL_WCNT);
  assign wrReload = regWrEn && (regSel == SEL_RCNT);
  assign wrCtrl   = regWrEn && (regSel == SEL_CTRL);

  assign lastXfer = (workCnt == CntW'(1));
  assign blockLen = (reloadCnt == '0) ? (SpanW'(1) << CntW) : SpanW'(reloadCnt);
  assign span     = sizeWord ? (blockLen << 1) : blockLen;
  assign stepAmt  = sizeWord ? AddrW'(2) : AddrW'(1);
  assign rewind   = lastXfer ? AddrW'(span) : '0;
  assign memNext  = decMode ? (memAddr - stepAmt + rewind)
                            : (memAddr + stepAmt - rewind);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr   <= '0;
      ioLow     <= '0;
      workCnt   <= '0;
      reloadCnt <= '0;
      chanEn    <= 1'b0;
      sizeWord  <= 1'b0;
      decMode   <= 1'b0;
      memToIo   <= 1'b0;
    end else begin
      if (wrMem)             memAddr <= regWrData;
      else if (strobes.step) memAddr <= memNext;

      if (wrWork)            workCnt <= regWrData[CntW-1:0];
      else if (strobes.step) workCnt <= lastXfer ? reloadCnt : workCnt - CntW'(1);

      if (wrIo)     ioLow     <= regWrData[IoW-1:0];
      if (wrReload) reloadCnt <= regWrData[CntW-1:0];
      if (wrCtrl) begin
        chanEn   <= regWrData[0];
        sizeWord <= regWrData[1];
        decMode  <= regWrData[2];
        memToIo  <= regWrData[3];
      end
    end
  end

  assign ioAddr   = {{(AddrW-IoW){1'b1}}, ioLow};
  assign srcAddr  = memToIo ? memAddr : ioAddr;
  assign dstAddr  = memToIo ? ioAddr : memAddr;
  assign xferWord = sizeWord;

  AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !lastXfer && !wrWork) |=> (workCnt == $past(workCnt) - CntW'(1))); // R6
  AST_COUNT_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && lastXfer && !wrWork && !wrReload) |=> (workCnt == reloadCnt)); // R6
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.step && !wrMem) |=> $stable(memAddr)); // R9
  AST_IO_STILL: assert property (@(posedge clk) disable iff (!rstN)
    (!wrIo) |=> $stable(ioLow)); // R8
endmodule

// File: rtl/dma_repeat_channel.sv
module dma_repeat_channel #(
  parameter int AddrW = 24,
  parameter int CntW  = 8,
  parameter int IoW   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             xferReq,
  input  logic             regWrEn,
  input  logic [2:0]       regSel,
  input  logic [AddrW-1:0] regWrData,
  input  logic             busDone,
  output logic             busReq,
  output logic [AddrW-1:0] srcAddr,
  output logic [AddrW-1:0] dstAddr,
  output logic             xferWord
);
  dmarep_pkg::ctrlStrobes_t strobes;
  logic chanEn;

  dmarep_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .xferReq (xferReq),
    .busDone (busDone),
    .chanEn  (chanEn),
    .busReq  (busReq),
    .strobes (strobes)
  );

  dmarep_datapath #(.AddrW(AddrW), .CntW(CntW), .IoW(IoW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regSel    (dmarep_pkg::regSel_t'(regSel)),
    .regWrData (regWrData),
    .strobes   (strobes),
    .chanEn    (chanEn),
    .srcAddr   (srcAddr),
    .dstAddr   (dstAddr),
    .xferWord  (xferWord)
  );
endmodule

// File: tb/tb_dma_repeat_channel.sv
`timescale 1ns/1ps
module tb_dma_repeat_channel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xferReq = 1'b0, regWrEn = 1'b0, busDone = 1'b0;
  logic [2:0]  regSel = '0;
  logic [23:0] regWrData = '0;
  logic        busReq, xferWord;
  logic [23:0] srcAddr, dstAddr;

  always #10 clk = ~clk;

  dma_repeat_channel dut (
    .clk(clk), .rstN(rstN), .xferReq(xferReq), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .busDone(busDone),
    .busReq(busReq), .srcAddr(srcAddr), .dstAddr(dstAddr), .xferWord(xferWord)
  );

  int nTests = 0, nFail = 0;
  bit done = 1'b0;

  typedef struct { logic [47:0] addrs; logic word; string tag; } exp_t;
  exp_t expQ[$];

  logic [23:0] mMem = '0;
  logic [7:0]  mIo = '0, mCnt = '0, mRel = '0;
  bit          mWord = 0, mDec = 0, mToIo = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pushExp(string tag);
    exp_t e;
    logic [23:0] io;
    io = {16'hFFFF, mIo};
    e.addrs = mToIo ? {mMem, io} : {io, mMem};
    e.word = mWord;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic modelStep();
    int n;
    logic [23:0] span;
    mMem = mDec ? mMem - (mWord ? 24'd2 : 24'd1) : mMem + (mWord ? 24'd2 : 24'd1);
    mCnt = mCnt - 8'd1;
    if (mCnt == 8'd0) begin
      mCnt = mRel;
      n = (mRel == 8'd0) ? 256 : int'(mRel);
      span = 24'(n * (mWord ? 2 : 1));
      mMem = mDec ? mMem + span : mMem - span;
    end
  endtask

  // R11 register map: 0 mem, 1 io, 2 work count, 3 reload, 4 control
  task automatic writeReg(logic [2:0] sel, logic [23:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
    case (sel)
      3'd0: mMem = data;
      3'd1: mIo = data[7:0];
      3'd2: mCnt = data[7:0];
      3'd3: mRel = data[7:0];
      default: begin mWord = data[1]; mDec = data[2]; mToIo = data[3]; end
    endcase
  endtask

  task automatic setup(logic [23:0] mem, logic [7:0] io, logic [7:0] cnt, logic [3:0] ctl);
    writeReg(3'd0, mem);
    writeReg(3'd1, {16'd0, io});
    writeReg(3'd2, {16'd0, cnt});
    writeReg(3'd3, {16'd0, cnt});
    writeReg(3'd4, {20'd0, ctl});
  endtask

  task automatic runXfer(string tag);
    pushExp(tag);
    @(negedge clk) xferReq = 1'b1;
    @(negedge clk) xferReq = 1'b0;
    check({tag, " R2 busReq up"}, 64'(busReq), 64'd1);
    busDone = 1'b1;
    @(negedge clk) busDone = 1'b0;
    check({tag, " R2 busReq down"}, 64'(busReq), 64'd0);
    modelStep();
  endtask

  // Scoreboard monitor: pops one expectation per transfer start
  logic prevReq = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (busReq && !prevReq) begin
        if (expQ.size() == 0) begin
          nTests++; nFail++;
          $display("FAIL R3 unexpected transfer actual src=%0h expected none", srcAddr);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check({e.tag, " addr"}, 64'({srcAddr, dstAddr}), 64'(e.addrs));
          check({e.tag, " size"}, 64'(xferWord), 64'(e.word));
        end
      end
      prevReq = busReq;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busReq", 64'(busReq), 64'd0);
    check("R1 src", 64'(srcAddr), 64'hFFFF00);
    check("R1 dst", 64'(dstAddr), 64'h000000);
    check("R1 size", 64'(xferWord), 64'd0);
    rstN = 1'b1;

    // R5 R8 R11 byte increment, memory to io; R6 R7 block end after 3
    setup(24'h001000, 8'h40, 8'd3, 4'b1001);
    for (int i = 0; i < 4; i++) runXfer("R5 R6 R7 R8 R11 byte inc");
    check("R7 rewound start", 64'(srcAddr), 64'h001001);

    // word decrement, io to memory, block of 2
    setup(24'h002000, 8'h7C, 8'd2, 4'b0111);
    for (int i = 0; i < 3; i++) runXfer("R5 R7 R8 word dec");

    // R3 disabled requests ignored; R9 resume keeps position
    writeReg(3'd4, 24'h000006);
    @(negedge clk) xferReq = 1'b1;
    @(negedge clk) xferReq = 1'b0;
    check("R3 no launch while off", 64'(busReq), 64'd0);
    writeReg(3'd4, 24'h000007);
    repeat (3) @(negedge clk);
    check("R3 request not queued", 64'(busReq), 64'd0);
    check("R9 held position", 64'(dstAddr), 64'(mMem));
    runXfer("R9 resume");
    runXfer("R9 R7 after resume");

    // R4 request during a transfer is held
    setup(24'h00FFFE, 8'h11, 8'd5, 4'b1001);
    pushExp("R4 first");
    @(negedge clk) xferReq = 1'b1;
    @(negedge clk);
    check("R4 in flight", 64'(busReq), 64'd1);
    @(negedge clk) begin xferReq = 1'b0; busDone = 1'b1; end
    @(negedge clk) busDone = 1'b0;
    check("R4 idle gap", 64'(busReq), 64'd0);
    modelStep();
    pushExp("R4 held request");
    @(negedge clk);
    check("R4 held launch", 64'(busReq), 64'd1);
    busDone = 1'b1;
    @(negedge clk) busDone = 1'b0;
    modelStep();

    // R5 R7 word decrement wrap across address zero
    setup(24'h000000, 8'h22, 8'd2, 4'b1111);
    for (int i = 0; i < 3; i++) runXfer("R5 R7 wrap");

    // R10 zero count means 256 transfers
    setup(24'h000300, 8'h33, 8'd0, 4'b1001);
    for (int i = 0; i < 257; i++) runXfer("R10 block 256");
    check("R10 rewind after 256", 64'(srcAddr), 64'h000301);

    repeat (2) @(negedge clk);
    check("R2 queue drained", 64'(expQ.size()), 64'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule